// File: doc/BRIEF.md
# Fault-Emulating Gate Test Harness

This block is a small circuit under test joined to a logic fault emulator and a built-in test applicator. It holds two copies of the same logic: a fault-free reference and a copy in which one modelled fault can be planted. The logic is the majority-like function F = x1·x2 + x2·x3 and a separate two-input NAND (inputs a and b, output y). The applicator drives one stored pattern per clock into both copies at once. It compares both outputs of the two copies and gives a Go/NoGo verdict. The verdict says whether any difference appeared. It does not say where the fault is.

In single mode, the caller picks one fault with a type code and a select code, then pulses `start`. In sweep mode, the block walks its whole list of 29 modelled faults and counts the ones it detects. Fault coverage is therefore `detCount` / 29. Four kinds of fault are emulated:
- stuck-at-0 and stuck-at-1 on any line;
- a short between two input lines that resolves as wired-AND or wired-OR;
- a stuck-open line, where the pull-up path is broken, so the line can fall but cannot rise and keeps its old value instead.

Top module: `gate_fault_harness`

## Requirements
- R1: After reset, `busy`, `done` and `goNogo` are 0 and `detCount` is 0.
- R2: Line codes for the function are x1=0, x2=1, x3=2 and F=3. Type 1 forces the selected line to 0 and type 2 forces it to 1. Pattern k (k = 0..NUM_PAT-1) drives x1=k[2], x2=k[1] and x3=k[0]. With the eight patterns, every stuck-at fault on lines 0..3 is detected. Line 0 stuck-at-0 turns F into x2·x3, which is detected.
- R3: Line codes for the NAND are a=4, b=5 and y=6. The NAND patterns cycle through (a,b) = 01, 10, 11, in that order, using index k mod 3. This three-pattern set detects all six stuck-at faults on a, b and y.
- R4: Type 3 is a wired-AND short and type 4 is a wired-OR short. The pair codes are 0 = x1–x2, 1 = x2–x3, 2 = x1–x3 and 3 = a–b. Both shorted lines take the resolved value. The x1–x3 wired-OR short and the a–b wired-AND short leave the outputs unchanged, so they are not detected. The other six shorts are detected.
- R5: Type 5 is stuck-open. When the selected line would be 1, it keeps its previous faulty value. When it would be 0, it goes to 0. All seven stuck-open faults are detected by a rising transition that follows a pattern which set the line to 0.
- R6: For a stuck-open fault, the first pattern only sets the line's initial value and is never scored. With NUM_PAT=1, no stuck-open fault is ever reported.
- R7: `goNogo` is 1 exactly when at least one fault of the run was detected. Type 0 (no fault) gives `goNogo`=0 and `detCount`=0.
- R8: `busy` is high for NUM_PAT cycles per fault, starting the cycle after `start`. `done` is a one-cycle pulse in the cycle `busy` falls.
- R9: In sweep mode, the faults run in this order: stuck-at-0 on lines 0..6, stuck-at-1 on lines 0..6, wired-AND on pairs 0..3, wired-OR on pairs 0..3, then stuck-open on lines 0..6. `detCount` ends at the number of these 29 faults that were detected.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running fault and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| sweep | input | 1 | 1 = step through the whole fault list, 0 = single fault |
| faultSel | input | 3 | Line code (types 1, 2, 5) or pair code (types 3, 4) |
| faultType | input | 3 | 0 none, 1 stuck-at-0, 2 stuck-at-1, 3 wired-AND short, 4 wired-OR short, 5 stuck-open |
| busy | output | 1 | Patterns are being applied |
| done | output | 1 | One-cycle end-of-run pulse |
| goNogo | output | 1 | 1 = malfunction seen |
| detCount | output | 5 | Number of faults detected in the run |

## Verification
Every fault in the list is run on its own through the full eight-pattern sequence. The verdict is compared with a bench model that evaluates both copies pattern by pattern. This separates faults the patterns expose from the two shorts that do not change the function.

A second instance applies only one pattern. It shows that a stuck-open line cannot be caught by a lone pattern, while stuck-at faults still can. Sweep runs on both instances check the totals and run lengths. A second `start` injected in the middle of a run checks that the pulse is ignored.

// File: rtl/fh_pkg.sv
package fh_pkg;
  localparam int N_LINES      = 7;
  localparam int N_PAIRS      = 4;
  localparam int PAT_W        = 3;
  localparam int TOTAL_FAULTS = 3 * N_LINES + 2 * N_PAIRS;
  localparam int CNT_W        = $clog2(TOTAL_FAULTS + 1);

  typedef enum logic [2:0] {
    FT_NONE  = 3'd0,
    FT_SA0   = 3'd1,
    FT_SA1   = 3'd2,
    FT_BAND  = 3'd3,
    FT_BOR   = 3'd4,
    FT_SOPEN = 3'd5
  } faultType_e;

  typedef struct packed {
    logic             apply;
    logic             firstPat;
    logic             clrHold;
    logic [PAT_W-1:0] patIdx;
    logic [1:0]       nandIdx;
    logic [2:0]       fType;
    logic [2:0]       fSel;
  } strobe_t;
endpackage

// File: rtl/fh_datapath.sv
module fh_datapath
  import fh_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t st,
  output logic    hit
);
  logic x1, x2, x3, a, b, goodF, goodY;
  logic isBr, brAnd;
  logic in0, in1, in2, in3, in4;
  logic f0, f1, f2, f3, f4, f5, f6;
  logic soHold, selVal;

  function automatic logic inj(input logic [2:0] idx, input logic drv,
                               input logic [2:0] ty, input logic [2:0] sel,
                               input logic hold, input logic first);
    logic r;
    r = drv;
    if (sel == idx) begin
      case (ty)
        FT_SA0:   r = 1'b0;
        FT_SA1:   r = 1'b1;
        FT_SOPEN: r = first ? drv : (drv & hold);
        default:  r = drv;
      endcase
    end
    return r;
  endfunction

  always_comb begin
    x1 = st.patIdx[2];
    x2 = st.patIdx[1];
    x3 = st.patIdx[0];
    a  = (st.nandIdx != 2'd0);
    b  = (st.nandIdx != 2'd1);
    goodF = (x1 & x2) | (x2 & x3);
    goodY = ~(a & b);

    isBr  = (st.fType == FT_BAND) || (st.fType == FT_BOR);
    brAnd = (st.fType == FT_BAND);
    in0 = x1; in1 = x2; in2 = x3; in3 = a; in4 = b;
    if (isBr) begin
      case (st.fSel)
        3'd0: begin in0 = brAnd ? (x1 & x2) : (x1 | x2); in1 = in0; end
        3'd1: begin in1 = brAnd ? (x2 & x3) : (x2 | x3); in2 = in1; end
        3'd2: begin in0 = brAnd ? (x1 & x3) : (x1 | x3); in2 = in0; end
        3'd3: begin in3 = brAnd ? (a & b) : (a | b); in4 = in3; end
        default: ;
      endcase
    end

    f0 = inj(3'd0, in0, st.fType, st.fSel, soHold, st.firstPat);
    f1 = inj(3'd1, in1, st.fType, st.fSel, soHold, st.firstPat);
    f2 = inj(3'd2, in2, st.fType, st.fSel, soHold, st.firstPat);
    f3 = inj(3'd3, (f0 & f1) | (f1 & f2), st.fType, st.fSel, soHold, st.firstPat);
    f4 = inj(3'd4, in3, st.fType, st.fSel, soHold, st.firstPat);
    f5 = inj(3'd5, in4, st.fType, st.fSel, soHold, st.firstPat);
    f6 = inj(3'd6, ~(f4 & f5), st.fType, st.fSel, soHold, st.firstPat);

    case (st.fSel)
      3'd0: selVal = f0;
      3'd1: selVal = f1;
      3'd2: selVal = f2;
      3'd3: selVal = f3;
      3'd4: selVal = f4;
      3'd5: selVal = f5;
      default: selVal = f6;
    endcase

    hit = st.apply && ((f3 != goodF) || (f6 != goodY)) &&
          !((st.fType == FT_SOPEN) && st.firstPat);
  end

  // Stuck-open memory: cleared on fault selection, then follows the faulty line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  soHold <= 1'b0;
    else if (st.clrHold)                         soHold <= 1'b0;
    else if (st.apply && st.fType == FT_SOPEN)   soHold <= selVal;
  end

  AST_SO_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st.apply && st.firstPat && st.fType == FT_SOPEN) |-> (f3 == goodF && f6 == goodY)); // R6
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st.apply && st.fType == FT_NONE) |-> (f3 == goodF && f6 == goodY)); // R7
endmodule

// File: rtl/fh_control.sv
module fh_control
  import fh_pkg::*;
#(
  parameter int NUM_PAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sweep,
  input  logic [2:0]       faultSel,
  input  logic [2:0]       faultType,
  input  logic             hit,
  output strobe_t          st,
  output logic             busy,
  output logic             done,
  output logic             goNogo,
  output logic [CNT_W-1:0] detCount
);
  typedef enum logic {S_IDLE, S_RUN} state_e;
  state_e           state;
  logic [2:0]       curType, curSel, lastSel;
  logic [PAT_W-1:0] patIdx;
  logic [1:0]       nandIdx;
  logic             sweepMode, hitAcc, faultHit, lastPat, lastFault, advance, launch;

  always_comb begin
    lastSel   = (curType == FT_BAND || curType == FT_BOR) ? 3'(N_PAIRS - 1) : 3'(N_LINES - 1);
    lastFault = (curType == FT_SOPEN) && (curSel == lastSel);
    lastPat   = (patIdx == PAT_W'(NUM_PAT - 1));
    faultHit  = hitAcc | hit;
    launch    = (state == S_IDLE) && start;
    advance   = (state == S_RUN) && lastPat && sweepMode && !lastFault;
    busy      = (state == S_RUN);
    st.apply    = busy;
    st.firstPat = (patIdx == '0);
    st.clrHold  = launch || advance;
    st.patIdx   = patIdx;
    st.nandIdx  = nandIdx;
    st.fType    = curType;
    st.fSel     = curSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; curType <= '0; curSel <= '0; patIdx <= '0; nandIdx <= '0;
      sweepMode <= 1'b0; hitAcc <= 1'b0; done <= 1'b0; goNogo <= 1'b0; detCount <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        state     <= S_RUN;
        sweepMode <= sweep;
        curType   <= sweep ? 3'(FT_SA0) : faultType;
        curSel    <= sweep ? 3'd0 : faultSel;
        patIdx    <= '0;
        nandIdx   <= '0;
        hitAcc    <= 1'b0;
        goNogo    <= 1'b0;
        detCount  <= '0;
      end else if (state == S_RUN) begin
        if (lastPat) begin
          if (faultHit) begin
            detCount <= detCount + 1'b1;
            goNogo   <= 1'b1;
          end
          patIdx  <= '0;
          nandIdx <= '0;
          hitAcc  <= 1'b0;
          if (advance) begin
            if (curSel == lastSel) begin
              curType <= curType + 3'd1;
              curSel  <= '0;
            end else begin
              curSel <= curSel + 3'd1;
            end
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end else begin
          patIdx  <= patIdx + 1'b1;
          nandIdx <= (nandIdx == 2'd2) ? 2'd0 : nandIdx + 2'd1;
          hitAcc  <= faultHit;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_GO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (goNogo == (detCount != '0))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (detCount == $past(detCount) || detCount == $past(detCount) + 1'b1)); // R9
  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    detCount <= CNT_W'(TOTAL_FAULTS)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sweepMode && start) |=> ($stable(curType) && $stable(curSel))); // R10
endmodule

// File: rtl/gate_fault_harness.sv
module gate_fault_harness
  import fh_pkg::*;
#(
  parameter int NUM_PAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sweep,
  input  logic [2:0]       faultSel,
  input  logic [2:0]       faultType,
  output logic             busy,
  output logic             done,
  output logic             goNogo,
  output logic [CNT_W-1:0] detCount
);
  strobe_t st;
  logic    hit;

  fh_control #(.NUM_PAT(NUM_PAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep(sweep),
    .faultSel(faultSel), .faultType(faultType), .hit(hit), .st(st),
    .busy(busy), .done(done), .goNogo(goNogo), .detCount(detCount)
  );

  fh_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .hit(hit)
  );

  initial begin
    AST_NUM_PAT_RANGE: assert (NUM_PAT >= 1 && NUM_PAT <= 8); // R2
  end
endmodule

// File: tb/tb_gate_fault_harness.sv
module tb_gate_fault_harness;
  localparam int CLK_PERIOD = 10;
  localparam int NP_LONG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startL = 1'b0, startS = 1'b0, sweep = 1'b0;
  logic [2:0] faultSel = '0, faultType = '0;
  logic busyL, doneL, goL, busyS, doneS, goS;
  logic [4:0] cntL, cntS;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_fault_harness #(.NUM_PAT(NP_LONG)) dut (
    .clk(clk), .rst_n(rst_n), .start(startL), .sweep(sweep), .faultSel(faultSel),
    .faultType(faultType), .busy(busyL), .done(doneL), .goNogo(goL), .detCount(cntL));

  gate_fault_harness #(.NUM_PAT(1)) dutShort (
    .clk(clk), .rst_n(rst_n), .start(startS), .sweep(sweep), .faultSel(faultSel),
    .faultType(faultType), .busy(busyS), .done(doneS), .goNogo(goS), .detCount(cntS));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model: applies the pattern list to a good and a faulty copy.
  function automatic bit mdl(input int t, input int s, input int np);
    bit hold, det, x1, x2, x3, a, b, gF, gY, w, d;
    bit i0, i1, i2, i3, i4;
    bit f[7];
    bit [2:0] kb;
    hold = 0; det = 0;
    for (int k = 0; k < np; k++) begin
      kb = 3'(k);
      x1 = kb[2]; x2 = kb[1]; x3 = kb[0];
      a = (k % 3) != 0; b = (k % 3) != 1;
      gF = (x1 & x2) | (x2 & x3); gY = !(a & b);
      i0 = x1; i1 = x2; i2 = x3; i3 = a; i4 = b;
      if (t == 3 || t == 4) begin
        case (s)
          0: begin w = (t == 3) ? (x1 & x2) : (x1 | x2); i0 = w; i1 = w; end
          1: begin w = (t == 3) ? (x2 & x3) : (x2 | x3); i1 = w; i2 = w; end
          2: begin w = (t == 3) ? (x1 & x3) : (x1 | x3); i0 = w; i2 = w; end
          default: begin w = (t == 3) ? (a & b) : (a | b); i3 = w; i4 = w; end
        endcase
      end
      for (int L = 0; L < 7; L++) begin
        case (L)
          0: d = i0;
          1: d = i1;
          2: d = i2;
          3: d = (f[0] & f[1]) | (f[1] & f[2]);
          4: d = i3;
          5: d = i4;
          default: d = !(f[4] & f[5]);
        endcase
        f[L] = d;
        if (L == s) begin
          if (t == 1) f[L] = 0;
          else if (t == 2) f[L] = 1;
          else if (t == 5) begin
            f[L] = (k == 0) ? d : (d & hold);
            hold = f[L];
          end
        end
      end
      if ((f[3] != gF || f[6] != gY) && !(t == 5 && k == 0)) det = 1;
    end
    return det;
  endfunction

  task automatic doRun(input bit sh, input int t, input int s, input bit sw,
                       input bit poke, input int pokeT,
                       output int busyCyc, output bit go, output int cnt);
    @(negedge clk);
    faultType = 3'(t); faultSel = 3'(s); sweep = sw;
    if (sh) startS = 1'b1; else startL = 1'b1;
    @(negedge clk);
    startS = 1'b0; startL = 1'b0; busyCyc = 0;
    while (!(sh ? doneS : doneL)) begin
      startL = 1'b0;
      if (sh ? busyS : busyL) busyCyc++;
      if (poke && busyCyc == 2) begin
        faultType = 3'(pokeT); faultSel = 3'd6; startL = 1'b1;
      end
      @(negedge clk);
    end
    startL = 1'b0;
    go  = sh ? goS : goL;
    cnt = sh ? int'(cntS) : int'(cntL);
    @(negedge clk);
    chk((sh ? doneS : doneL) == 1'b0, "R8 done pulse width", int'(sh ? doneS : doneL), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bc, cnt, expTot, expShort, lim;
    bit go, e;
    string tag;
    repeat (3) @(negedge clk);
    chk(busyL == 0 && doneL == 0 && goL == 0 && cntL == 0, "R1 reset long", int'(cntL), 0);
    chk(busyS == 0 && doneS == 0 && goS == 0 && cntS == 0, "R1 reset short", int'(cntS), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busyL == 0 && goL == 0 && cntL == 0, "R1 after reset release", int'(cntL), 0);

    // R7: no fault
    doRun(0, 0, 0, 0, 0, 0, bc, go, cnt);
    chk(go == 0, "R7 no-fault goNogo", go, 0);
    chk(cnt == 0, "R7 no-fault count", cnt, 0);
    chk(bc == NP_LONG, "R8 busy length", bc, NP_LONG);

    // Every single fault on the long instance
    expTot = 0;
    for (int t = 1; t <= 5; t++) begin
      lim = (t == 3 || t == 4) ? 4 : 7;
      for (int s = 0; s < lim; s++) begin
        e = mdl(t, s, NP_LONG);
        expTot += int'(e);
        if (t == 3 || t == 4) tag = "R4 short";
        else if (t == 5) tag = "R5 stuck-open";
        else if (s <= 3) tag = "R2 stuck-at function";
        else tag = "R3 stuck-at nand";
        doRun(0, t, s, 0, 0, 0, bc, go, cnt);
        chk(go == e, $sformatf("%s t=%0d s=%0d goNogo", tag, t, s), go, e);
        chk(cnt == int'(e), $sformatf("%s t=%0d s=%0d count", tag, t, s), cnt, int'(e));
        chk(bc == NP_LONG, "R8 busy length per fault", bc, NP_LONG);
      end
    end

    // Named corner cases
    doRun(0, 1, 0, 0, 0, 0, bc, go, cnt);
    chk(go == 1, "R2 x1 stuck-at-0 gives x2*x3", go, 1);
    doRun(0, 4, 2, 0, 0, 0, bc, go, cnt);
    chk(go == 0, "R4 x1-x3 wired-OR undetectable", go, 0);
    doRun(0, 3, 3, 0, 0, 0, bc, go, cnt);
    chk(go == 0, "R4 a-b wired-AND undetectable", go, 0);
    chk(expTot == 27, "R9 model total", expTot, 27);

    // R10: start during busy ignored
    doRun(0, 0, 0, 0, 1, 2, bc, go, cnt);
    chk(go == 0, "R10 restart ignored (none then SA1)", go, 0);
    chk(bc == NP_LONG, "R10 run length unchanged", bc, NP_LONG);
    doRun(0, 1, 0, 0, 1, 0, bc, go, cnt);
    chk(go == 1, "R10 restart ignored (SA0 then none)", go, 1);

    // R9: sweep on long instance
    doRun(0, 0, 0, 1, 0, 0, bc, go, cnt);
    chk(cnt == expTot, "R9 sweep count", cnt, expTot);
    chk(go == 1, "R9 sweep goNogo", go, 1);
    chk(bc == 29 * NP_LONG, "R9 sweep length", bc, 29 * NP_LONG);

    // R6: one pattern only
    for (int s = 0; s < 7; s++) begin
      doRun(1, 5, s, 0, 0, 0, bc, go, cnt);
      chk(go == 0 && cnt == 0, $sformatf("R6 single pattern stuck-open s=%0d", s), cnt, 0);
    end
    doRun(1, 1, 6, 0, 0, 0, bc, go, cnt);
    chk(go == mdl(1, 6, 1), "R6 single pattern stuck-at still seen", go, int'(mdl(1, 6, 1)));
    expShort = 0;
    for (int t = 1; t <= 5; t++) begin
      lim = (t == 3 || t == 4) ? 4 : 7;
      for (int s = 0; s < lim; s++) expShort += int'(mdl(t, s, 1));
    end
    doRun(1, 0, 0, 1, 0, 0, bc, go, cnt);
    chk(cnt == expShort, "R6 R9 short sweep count", cnt, expShort);
    chk(bc == 29, "R9 short sweep length", bc, 29);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule